// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Lookup

This block is the lookup stage of a four-way set-associative first-level data cache with 128 sets and 32-byte lines (16 KB). A load presents only the untranslated page-offset bits of its virtual address. The set index and the word select both lie inside that 12-bit page offset, so the block reads every way's tag and line for the set while the address translator is still working on the page number.

One cycle after the request, the translator delivers a physical page number, a valid strobe and a fault flag. The block compares the page number with the tags it has already read. A match returns the addressed 32-bit word. A mismatch in every way issues a line-aligned miss request to the next level. A translation fault cancels the access without any visible effect.

Lines are installed through a fill port. The fill puts the line in the lowest-numbered invalid way of its set. When the set is full, it uses a per-set round-robin pointer instead.

Top module: `vipt_cache`

## Requirements
- R1: Geometry is 128 sets × 4 ways × 32-byte lines. The set index is reqPageOffset[11:5] and the word select is reqPageOffset[4:2]. Word w of a line occupies bits [32w+31:32w] of the line data.
- R2: Translation (xlatValid, xlatFault, xlatPpn) is presented in the cycle after the request. The outcome (rspValid or missValid) is a one-cycle pulse registered at the second rising edge after the request. Nothing is signalled at the first edge.
- R3: A hit is a valid way of the indexed set whose 20-bit tag equals xlatPpn. It gives rspValid=1 and rspErr=0, with rspData equal to the selected word of that line. At most one way hits.
- R4: If no way hits, missValid=1 and missLineAddr = {xlatPpn, set index, 5'b0}. No response is given.
- R5: With xlatValid=1 and xlatFault=1, an aligned request gives neither a response nor a miss, and it changes no cache state.
- R6: A request whose reqPageOffset[1:0] is nonzero gives rspValid=1 and rspErr=1 and no miss, whatever the translation inputs are.
- R7: A fill (fillValid=1) installs fillData as the line at physical line address fillLine = {tag[19:0], set[6:0]}. Later lookups of that line hit.
- R8: A fill goes to the lowest-numbered invalid way of its set. Four fills of distinct tags into an empty set therefore all stay resident.
- R9: When the set is full, the fill replaces the way named by that set's pointer, which starts at way 0 and advances by one (mod 4) on each such fill. Each set has its own pointer.
- R10: After reset no line is valid, and rspValid, rspErr and missValid are 0.
- R11: An aligned request without xlatValid in its second cycle produces neither a response nor a miss. A response and a miss never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Load request strobe |
| reqPageOffset | input | 12 | Untranslated page-offset bits of the virtual address |
| xlatValid | input | 1 | Translation result valid (cycle after request) |
| xlatFault | input | 1 | Translation fault; cancels the access |
| xlatPpn | input | 20 | Translated physical page number |
| fillValid | input | 1 | Line fill strobe |
| fillLine | input | 27 | Physical line address {tag, set} of the fill |
| fillData | input | 256 | Fill line data, word 0 in the low bits |
| rspValid | output | 1 | Response pulse (hit or alignment error) |
| rspErr | output | 1 | Response is an alignment error |
| rspData | output | 32 | Returned word on a hit |
| missValid | output | 1 | Miss request pulse to the next level |
| missLineAddr | output | 32 | Line-aligned physical address of the miss |

## Verification
The assertions check, on every cycle, the behaviours that can be seen from port history alone. These are:
- the fixed two-edge latency from request to outcome;
- the error pulse for misaligned requests;
- silence after a faulted or untranslated request;
- that responses and misses are mutually exclusive;
- that at most one way matches;
- that each fill selects exactly one way.

Only the bench's scenarios can show that the returned word is the right one across a sweep of sets, tags and word offsets, that the miss address is well formed, that the way order prefers invalid ways first, and that round-robin eviction proceeds per set. The same applies to showing that a faulted access leaves the cache contents intact: later hits and misses reveal it.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  parameter int unsigned PA_W       = 32;
  parameter int unsigned PAGE_OFF_W = 12;
  parameter int unsigned SETS       = 128;
  parameter int unsigned WAYS       = 4;
  parameter int unsigned LINE_BYTES = 32;
  parameter int unsigned WORD_BYTES = 4;

  localparam int unsigned IDX_W       = $clog2(SETS);
  localparam int unsigned OFF_W       = $clog2(LINE_BYTES);
  localparam int unsigned TAG_W       = PA_W - PAGE_OFF_W;
  localparam int unsigned LINE_W      = LINE_BYTES * 8;
  localparam int unsigned WORD_W      = WORD_BYTES * 8;
  localparam int unsigned BSEL_W      = $clog2(WORD_BYTES);
  localparam int unsigned WSEL_W      = OFF_W - BSEL_W;
  localparam int unsigned WAY_W       = $clog2(WAYS);
  localparam int unsigned LINE_ADDR_W = PA_W - OFF_W;
  localparam int unsigned IW_W        = PAGE_OFF_W - BSEL_W;

  // control-to-datapath strobes
  typedef struct packed {
    logic            s1Load;
    logic            rspLoad;
    logic            missLoad;
    logic            fillWrite;
    logic [WAYS-1:0] fillWayOh;
  } strobe_t;
endpackage

// File: rtl/vipt_dpath.sv
module vipt_dpath
  import vipt_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobe,
  input  logic [IW_W-1:0]        reqIdxWord,
  input  logic [TAG_W-1:0]       xlatPpn,
  input  logic [LINE_ADDR_W-1:0] fillLine,
  input  logic [LINE_W-1:0]      fillData,
  output logic [WAYS-1:0]        hitVec,
  output logic [WAYS-1:0]        fillSetValid,
  output logic [WORD_W-1:0]      rspData,
  output logic [PA_W-1:0]        missAddr
);
  logic [TAG_W-1:0]  tagMem  [SETS][WAYS];
  logic [LINE_W-1:0] dataMem [SETS][WAYS];
  logic [WAYS-1:0]   validMem [SETS];

  logic [IDX_W-1:0]  reqIdx;
  logic [WSEL_W-1:0] reqWord;
  logic [IDX_W-1:0]  fillIdx;
  logic [TAG_W-1:0]  fillTag;

  logic [IDX_W-1:0]  s1Idx;
  logic [WSEL_W-1:0] s1Word;
  logic [WAYS-1:0]   s1Valids;
  logic [TAG_W-1:0]  s1Tags  [WAYS];
  logic [LINE_W-1:0] s1Lines [WAYS];
  logic [WORD_W-1:0] hitWord;

  assign reqIdx       = reqIdxWord[IW_W-1:WSEL_W];
  assign reqWord      = reqIdxWord[WSEL_W-1:0];
  assign fillIdx      = fillLine[IDX_W-1:0];
  assign fillTag      = fillLine[LINE_ADDR_W-1:IDX_W];
  assign fillSetValid = validMem[fillIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) validMem[s] <= '0;
    end else if (strobe.fillWrite) begin
      validMem[fillIdx] <= validMem[fillIdx] | strobe.fillWayOh;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWrite) begin
      for (int w = 0; w < WAYS; w++) begin
        if (strobe.fillWayOh[w]) begin
          tagMem[fillIdx][w]  <= fillTag;
          dataMem[fillIdx][w] <= fillData;
        end
      end
    end
  end

  // stage 1: set read overlapping translation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Idx    <= '0;
      s1Word   <= '0;
      s1Valids <= '0;
    end else if (strobe.s1Load) begin
      s1Idx    <= reqIdx;
      s1Word   <= reqWord;
      s1Valids <= validMem[reqIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.s1Load) begin
      for (int w = 0; w < WAYS; w++) begin
        s1Tags[w]  <= tagMem[reqIdx][w];
        s1Lines[w] <= dataMem[reqIdx][w];
      end
    end
  end

  // stage 2: physical tag compare
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = s1Valids[w] && (s1Tags[w] == xlatPpn);
  end

  always_comb begin
    hitWord = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) hitWord = hitWord | s1Lines[w][s1Word*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspData  <= '0;
      missAddr <= '0;
    end else begin
      if (strobe.rspLoad)  rspData  <= hitWord;
      if (strobe.missLoad) missAddr <= {xlatPpn, s1Idx, {OFF_W{1'b0}}};
    end
  end
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [BSEL_W-1:0] reqByteSel,
  input  logic              xlatValid,
  input  logic              xlatFault,
  input  logic [WAYS-1:0]   hitVec,
  input  logic              fillValid,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [WAYS-1:0]   fillSetValid,
  output strobe_t           strobe,
  output logic              rspValid,
  output logic              rspErr,
  output logic              missValid
);
  logic             s1Valid;
  logic             s1Misal;
  logic [WAY_W-1:0] rrPtr [SETS];
  logic             stErr, stHit, stMiss, xlatOk, freeFound, setFull;
  logic [WAYS-1:0]  victimOh;

  assign xlatOk  = xlatValid && !xlatFault;
  assign stErr   = s1Valid && s1Misal;
  assign stHit   = s1Valid && !s1Misal && xlatOk && (|hitVec);
  assign stMiss  = s1Valid && !s1Misal && xlatOk && !(|hitVec);
  assign setFull = &fillSetValid;

  always_comb begin
    freeFound = 1'b0;
    victimOh  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!freeFound && !fillSetValid[w]) begin
        victimOh[w] = 1'b1;
        freeFound   = 1'b1;
      end
    end
    if (!freeFound) victimOh[rrPtr[fillIdx]] = 1'b1;
  end

  always_comb begin
    strobe.s1Load    = reqValid;
    strobe.rspLoad   = stHit;
    strobe.missLoad  = stMiss;
    strobe.fillWrite = fillValid;
    strobe.fillWayOh = victimOh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid   <= 1'b0;
      s1Misal   <= 1'b0;
      rspValid  <= 1'b0;
      rspErr    <= 1'b0;
      missValid <= 1'b0;
      for (int s = 0; s < SETS; s++) rrPtr[s] <= '0;
    end else begin
      s1Valid   <= reqValid;
      s1Misal   <= reqValid && (reqByteSel != '0);
      rspValid  <= stErr || stHit;
      rspErr    <= stErr;
      missValid <= stMiss;
      if (fillValid && setFull) begin
        if (rrPtr[fillIdx] == WAY_W'(WAYS - 1)) rrPtr[fillIdx] <= '0;
        else rrPtr[fillIdx] <= rrPtr[fillIdx] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [PAGE_OFF_W-1:0]  reqPageOffset,
  input  logic                   xlatValid,
  input  logic                   xlatFault,
  input  logic [TAG_W-1:0]       xlatPpn,
  input  logic                   fillValid,
  input  logic [LINE_ADDR_W-1:0] fillLine,
  input  logic [LINE_W-1:0]      fillData,
  output logic                   rspValid,
  output logic                   rspErr,
  output logic [WORD_W-1:0]      rspData,
  output logic                   missValid,
  output logic [PA_W-1:0]        missLineAddr
);
  strobe_t         strobe;
  logic [WAYS-1:0] hitVec;
  logic [WAYS-1:0] fillSetValid;

  vipt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqByteSel(reqPageOffset[BSEL_W-1:0]),
    .xlatValid(xlatValid), .xlatFault(xlatFault),
    .hitVec(hitVec),
    .fillValid(fillValid), .fillIdx(fillLine[IDX_W-1:0]), .fillSetValid(fillSetValid),
    .strobe(strobe),
    .rspValid(rspValid), .rspErr(rspErr), .missValid(missValid)
  );

  vipt_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqIdxWord(reqPageOffset[PAGE_OFF_W-1:BSEL_W]),
    .xlatPpn(xlatPpn),
    .fillLine(fillLine), .fillData(fillData),
    .hitVec(hitVec), .fillSetValid(fillSetValid),
    .rspData(rspData), .missAddr(missLineAddr)
  );
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk
  import vipt_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic [PAGE_OFF_W-1:0] reqPageOffset,
  input logic                  xlatValid,
  input logic                  xlatFault,
  input logic                  rspValid,
  input logic                  rspErr,
  input logic                  missValid,
  input logic [WAYS-1:0]       hitVec,
  input logic                  fillValid,
  input logic [WAYS-1:0]       fillWayOh
);
  a_r6_misaligned_err: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqPageOffset[BSEL_W-1:0] != '0) |=> ##1 (rspValid && rspErr && !missValid));

  a_r5_fault_silent: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqPageOffset[BSEL_W-1:0] == '0) ##1 (xlatValid && xlatFault)
      |=> (!rspValid && !missValid));

  a_r11_no_xlat_silent: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqPageOffset[BSEL_W-1:0] == '0) ##1 !xlatValid
      |=> (!rspValid && !missValid));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rspValid && missValid));

  a_r2_outcome_latency: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid || missValid) |-> $past(reqValid, 2));

  a_r3_single_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  a_r8_fill_one_way: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> $onehot(fillWayOh));

  a_r6_err_has_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);
endmodule

bind vipt_cache vipt_cache_chk chk_i (
  .clk(clk), .rstN(rstN),
  .reqValid(reqValid), .reqPageOffset(reqPageOffset),
  .xlatValid(xlatValid), .xlatFault(xlatFault),
  .rspValid(rspValid), .rspErr(rspErr), .missValid(missValid),
  .hitVec(hitVec), .fillValid(fillValid), .fillWayOh(strobe.fillWayOh)
);

// File: tb/vipt_cache_tb.sv
module vipt_cache_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [11:0]  reqPageOffset = '0;
  logic         xlatValid = 1'b0;
  logic         xlatFault = 1'b0;
  logic [19:0]  xlatPpn = '0;
  logic         fillValid = 1'b0;
  logic [26:0]  fillLine = '0;
  logic [255:0] fillData = '0;
  logic         rspValid, rspErr, missValid;
  logic [31:0]  rspData, missLineAddr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  vipt_cache dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqPageOffset(reqPageOffset),
    .xlatValid(xlatValid), .xlatFault(xlatFault), .xlatPpn(xlatPpn),
    .fillValid(fillValid), .fillLine(fillLine), .fillData(fillData),
    .rspValid(rspValid), .rspErr(rspErr), .rspData(rspData),
    .missValid(missValid), .missLineAddr(missLineAddr)
  );

  function automatic logic [31:0] expWord(input logic [19:0] tag, input logic [6:0] idx,
                                          input int w);
    return (32'(tag) << 12) ^ (32'(idx) << 5) ^ (32'(w) * 32'h01010101) ^ 32'h5A000000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doFill(input logic [19:0] tag, input logic [6:0] idx);
    @(negedge clk);
    fillValid = 1'b1;
    fillLine  = {tag, idx};
    for (int w = 0; w < 8; w++) fillData[w*32 +: 32] = expWord(tag, idx, w);
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  // request at one negedge, translation at the next, outcome after the second edge
  task automatic doLookup(input logic [11:0] off, input logic [19:0] ppn, input bit xv,
                          input bit fault, output bit early, output bit rv, output bit re,
                          output bit mv, output logic [31:0] rd, output logic [31:0] ma);
    @(negedge clk);
    reqValid = 1'b1;
    reqPageOffset = off;
    @(posedge clk);
    #1 early = rspValid | missValid;
    @(negedge clk);
    reqValid  = 1'b0;
    xlatValid = xv;
    xlatFault = fault;
    xlatPpn   = ppn;
    @(posedge clk);
    #1;
    rv = rspValid; re = rspErr; mv = missValid; rd = rspData; ma = missLineAddr;
    @(negedge clk);
    xlatValid = 1'b0;
    xlatFault = 1'b0;
  endtask

  function automatic logic [6:0] sweepSet(input int i);
    case (i)
      0: return 7'd0;
      1: return 7'd1;
      2: return 7'd64;
      default: return 7'd127;
    endcase
  endfunction

  function automatic logic [19:0] sweepTag(input int si, input int t);
    return 20'h10000 + 20'(si * 16 + t);
  endfunction

  task automatic expectHit(input logic [19:0] tag, input logic [6:0] idx, input int w,
                           input string req);
    bit e, rv, re, mv;
    logic [31:0] rd, ma;
    doLookup({idx, 3'(w), 2'b00}, tag, 1'b1, 1'b0, e, rv, re, mv, rd, ma);
    check(rv && !re && !mv, req, {29'b0, rv, re, mv}, 32'h4);
    check(rd == expWord(tag, idx, w), req, rd, expWord(tag, idx, w));
  endtask

  task automatic expectMiss(input logic [19:0] tag, input logic [6:0] idx, input string req);
    bit e, rv, re, mv;
    logic [31:0] rd, ma;
    doLookup({idx, 3'd2, 2'b00}, tag, 1'b1, 1'b0, e, rv, re, mv, rd, ma);
    check(!rv && mv, req, {30'b0, rv, mv}, 32'h1);
    check(ma == {tag, idx, 5'b0}, req, ma, {tag, idx, 5'b0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit e, rv, re, mv;
    logic [31:0] rd, ma;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10: outputs quiet after reset
    check(!rspValid && !rspErr && !missValid, "R10 reset outputs",
          {29'b0, rspValid, rspErr, missValid}, 32'h0);
    // R10 R2: empty cache misses, nothing at the first edge
    doLookup({7'd5, 3'd1, 2'b00}, 20'h00123, 1'b1, 1'b0, e, rv, re, mv, rd, ma);
    check(!e, "R2 nothing at first edge", {31'b0, e}, 32'h0);
    check(mv && !rv, "R10 empty cache misses", {30'b0, rv, mv}, 32'h1);
    check(ma == {20'h00123, 7'd5, 5'b0}, "R4 miss address after reset", ma,
          {20'h00123, 7'd5, 5'b0});

    // R1 R3 R7 R8: fill four tags per set, then sweep every word of every line
    for (int si = 0; si < 4; si++)
      for (int t = 0; t < 4; t++) doFill(sweepTag(si, t), sweepSet(si));
    for (int si = 0; si < 4; si++)
      for (int t = 0; t < 4; t++)
        for (int w = 0; w < 8; w++)
          expectHit(sweepTag(si, t), sweepSet(si), w, "R1 R3 R7 R8 sweep hit");

    // R4: absent tag in a populated set
    expectMiss(20'h0ABCD, 7'd64, "R4 miss in full set");

    // R9: round robin in set 1 (full, pointer at way 0)
    doFill(20'h2AAAA, 7'd1);
    expectMiss(sweepTag(1, 0), 7'd1, "R9 first eviction is way 0");
    expectHit(20'h2AAAA, 7'd1, 3, "R9 replacement line hits");
    expectHit(sweepTag(1, 1), 7'd1, 0, "R9 way 1 survives");
    doFill(20'h2BBBB, 7'd1);
    expectMiss(sweepTag(1, 1), 7'd1, "R9 second eviction is way 1");
    expectHit(sweepTag(1, 2), 7'd1, 7, "R9 way 2 survives");
    // R9: set 0 pointer untouched by set 1 fills
    doFill(20'h2CCCC, 7'd0);
    expectMiss(sweepTag(0, 0), 7'd0, "R9 per-set pointer");
    expectHit(sweepTag(0, 1), 7'd0, 4, "R9 per-set pointer keeps way 1");

    // R5: fault cancels without state change
    doLookup({7'd127, 3'd3, 2'b00}, sweepTag(3, 0), 1'b1, 1'b1, e, rv, re, mv, rd, ma);
    check(!rv && !mv, "R5 fault on present line silent", {30'b0, rv, mv}, 32'h0);
    expectHit(sweepTag(3, 0), 7'd127, 3, "R5 line intact after fault");
    doLookup({7'd100, 3'd0, 2'b00}, 20'h03333, 1'b1, 1'b1, e, rv, re, mv, rd, ma);
    check(!rv && !mv, "R5 fault on absent line silent", {30'b0, rv, mv}, 32'h0);
    expectMiss(20'h03333, 7'd100, "R5 no fill after fault");

    // R6: misaligned sweep, with and without translation
    for (int b = 1; b < 4; b++) begin
      for (int x = 0; x < 2; x++) begin
        doLookup({7'd127, 3'd2, 2'(b)}, sweepTag(3, 1), x[0], 1'b0, e, rv, re, mv, rd, ma);
        check(rv && re && !mv, "R6 misaligned error", {29'b0, rv, re, mv}, 32'h6);
      end
    end

    // R11: no translation strobe means no outcome
    doLookup({7'd127, 3'd2, 2'b00}, sweepTag(3, 1), 1'b0, 1'b0, e, rv, re, mv, rd, ma);
    check(!rv && !mv, "R11 untranslated request silent", {30'b0, rv, mv}, 32'h0);
    expectHit(sweepTag(3, 1), 7'd127, 2, "R11 later lookup still hits");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule